// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block supervises a processor by driving an active-low reset line. Three events pull that line low: the block's own power-up, a watchdog timeout, and a digital "supply below threshold" indication from an external comparator. Once the line is low, it stays low for a fixed width measured in prescaled ticks. Any further event that arrives during that window starts the full width again.

Software controls the watchdog through a small register port. One register turns the watchdog on and sets its timeout in whole units of 100 ms. The counter restarts only when a fixed 4-bit key is written, so a stray write does not keep the watchdog from expiring. A second register holds three sticky flags that record what caused the reset. A third register selects one of four comparator thresholds and passes that choice out to the analog side.

Timing is set by parameters. `TICK_DIV` is the number of clocks per tick, `UNIT_TICKS` is the number of ticks in one timeout unit (100 ms), and `PULSE_TICKS` is the reset width in ticks (100 ms).

Top module: `wdt_supervisor`

## Requirements
- R1: When `rst_n` is released, `rst_out_n` stays low for exactly PULSE_TICKS×TICK_DIV clock edges. After that, the flag register (address 1) reads 0x40, meaning only the power-up flag is set.
- R2: Every reset event drives `rst_out_n` low at the next clock edge. The line then stays low for exactly PULSE_TICKS×TICK_DIV clock edges, provided no further event arrives.
- R3: Address 0 is the watchdog control register: bit 7 enables the watchdog and bits 4:0 give the timeout T. With the watchdog enabled and T nonzero, it expires T×UNIT_TICKS×TICK_DIV clock edges after a restart. With bit 7 clear, or with T = 0, it never expires.
- R4: The watchdog restarts from zero only when a write to address 1 carries 4'b1010 in bits 3:0. Any other value in those bits leaves the countdown unchanged.
- R5: While `lvd_below` is high, `rst_out_n` stays low and the low-voltage flag (bit 5 of address 1) is set. The line is released PULSE_TICKS×TICK_DIV edges after the last cycle in which the input was high.
- R6: A reset event that arrives while `rst_out_n` is already low restarts the full pulse width from that event.
- R7: The cause flags sit in address 1: bit 7 for watchdog, bit 6 for power-up, bit 5 for low voltage. Each flag stays set until software writes a 1 to its bit. If a source fires in the same cycle as that clearing write, the flag stays set.
- R8: Register readback works as follows. Address 0 returns bits 7 and 4:0 as written, with bits 6:5 reading 0. Address 2 returns its bits 1:0 with all other bits 0, and `lvd_sel` equals those two bits. Address 3 always reads 0.
- R9: The watchdog count is held at zero while `rst_out_n` is low. After any reset, the next expiry comes a full timeout after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| lvd_below | input | 1 | Comparator output: supply is below the selected threshold |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| lvd_sel | output | 2 | Threshold selection sent to the comparator |
| rst_out_n | output | 1 | Supervised reset output, active low |

## Verification
The bench counts exact cycle widths. A design that lets the prescaler phase drift into the pulse or the timeout would be off by up to one tick. The bench writes a wrong key partway through a countdown; a decoder that treats any write as a restart would expire late. It retriggers during an active pulse and holds the low-voltage input for many cycles; a one-shot stretcher would release too early. It also forces a reset just before a timeout is due and then measures the full timeout after release, which catches a counter that kept running while the output was low. Finally, it sets a flag and clears it in the same cycle; the flag must remain set, so a design that lets the clear win would lose the cause.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;
    localparam int REG_AW = 2;
    localparam int REG_DW = 8;
    localparam int SEL_W  = 5;
    localparam int VSEL_W = 2;

    localparam logic [REG_AW-1:0] ADDR_CTL   = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_CAUSE = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_VSEL  = 2'd2;

    localparam logic [3:0] RESTART_KEY = 4'b1010;

    typedef struct packed {
        logic wdt;
        logic por;
        logic lv;
    } cause_t;
endpackage

// File: rtl/wdsup_tick.sv
module wdsup_tick #(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [W-1:0] div;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.div == W'(DIV - 1));
        if (restart || tick) s_d.div = '0;
        else                 s_d.div = s_q.div + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wdsup_stretch.sv
module wdsup_stretch #(
    parameter int PULSE_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic tick,
    output logic active
);
    localparam int W = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic [W-1:0] left;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        active = (s_q.left != '0);
        if (trigger)             s_d.left = W'(PULSE_TICKS);
        else if (tick && active) s_d.left = s_q.left - W'(1);
    end

    // power-up counts as a reset event: start loaded
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{left: W'(PULSE_TICKS)};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wdsup_wdog.sv
module wdsup_wdog #(
    parameter int UNIT_TICKS = 100,
    parameter int SEL_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] sel,
    input  logic             kick,
    input  logic             hold,
    input  logic             tick,
    output logic             expire
);
    localparam int LIMIT_MAX = ((1 << SEL_W) - 1) * UNIT_TICKS;
    localparam int CW        = $clog2(LIMIT_MAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t           s_d, s_q;
    logic          armed;
    logic [CW-1:0] limit;

    always_comb begin
        s_d    = s_q;
        limit  = CW'(sel) * CW'(UNIT_TICKS);
        armed  = enable && (sel != '0) && !hold;
        expire = armed && !kick && tick && ((s_q.cnt + CW'(1)) == limit);
        if (!armed || kick || expire) s_d.cnt = '0;
        else if (tick)                s_d.cnt = s_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
    import wdsup_pkg::*;
#(
    parameter int TICK_DIV    = 50000,
    parameter int UNIT_TICKS  = 100,
    parameter int PULSE_TICKS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvd_below,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic [VSEL_W-1:0] lvd_sel,
    output logic              rst_out_n
);
    typedef struct packed {
        logic              wd_en;
        logic [SEL_W-1:0]  wd_sel;
        logic [VSEL_W-1:0] vsel;
        cause_t            cause;
    } st_t;

    localparam st_t RESET_ST = '{wd_en: 1'b0, wd_sel: '0, vsel: '0,
                                 cause: '{wdt: 1'b0, por: 1'b1, lv: 1'b0}};

    st_t  s_d, s_q;
    logic tick, kick, wd_expire, pulse_active, event_any, tick_restart;
    logic wr_ctl, wr_cause, wr_vsel;

    always_comb begin
        s_d          = s_q;
        wr_ctl       = reg_we && (reg_addr == ADDR_CTL);
        wr_cause     = reg_we && (reg_addr == ADDR_CAUSE);
        wr_vsel      = reg_we && (reg_addr == ADDR_VSEL);
        kick         = wr_cause && (reg_wdata[3:0] == RESTART_KEY);
        event_any    = wd_expire || lvd_below;
        tick_restart = event_any || (kick && !pulse_active);

        if (wr_ctl) begin
            s_d.wd_en  = reg_wdata[7];
            s_d.wd_sel = reg_wdata[SEL_W-1:0];
        end
        if (wr_vsel) s_d.vsel = reg_wdata[VSEL_W-1:0];
        if (wr_cause) begin
            if (reg_wdata[7]) s_d.cause.wdt = 1'b0;
            if (reg_wdata[6]) s_d.cause.por = 1'b0;
            if (reg_wdata[5]) s_d.cause.lv  = 1'b0;
        end
        // a firing source wins over a same-cycle clear
        if (wd_expire) s_d.cause.wdt = 1'b1;
        if (lvd_below) s_d.cause.lv  = 1'b1;

        unique case (reg_addr)
            ADDR_CTL:   reg_rdata = {s_q.wd_en, 2'b00, s_q.wd_sel};
            ADDR_CAUSE: reg_rdata = {s_q.cause, 5'b00000};
            ADDR_VSEL:  reg_rdata = {{(REG_DW-VSEL_W){1'b0}}, s_q.vsel};
            default:    reg_rdata = '0;
        endcase

        lvd_sel   = s_q.vsel;
        rst_out_n = !pulse_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RESET_ST;
        else        s_q <= s_d;
    end

    wdsup_tick #(.DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tick_restart),
        .tick    (tick)
    );

    wdsup_wdog #(.UNIT_TICKS(UNIT_TICKS), .SEL_W(SEL_W)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (s_q.wd_en),
        .sel    (s_q.wd_sel),
        .kick   (kick),
        .hold   (pulse_active),
        .tick   (tick),
        .expire (wd_expire)
    );

    wdsup_stretch #(.PULSE_TICKS(PULSE_TICKS)) u_stretch (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (event_any),
        .tick    (tick),
        .active  (pulse_active)
    );
endmodule

// File: rtl/wdsup_checker.sv
module wdsup_checker (
    input logic clk,
    input logic rst_n,
    input logic lvd_below,
    input logic rst_out_n,
    input logic tick,
    input logic wd_expire,
    input logic wd_en,
    input logic flag_wdt,
    input logic flag_lv,
    input logic clr_wdt
);
    p_event_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_expire || lvd_below) |=> !rst_out_n);

    p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> $past(tick));

    p_disabled_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |-> !wd_expire);

    p_lv_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lvd_below |=> (flag_lv && !rst_out_n));

    p_wdt_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> flag_wdt);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wdt && !clr_wdt) |=> flag_wdt);

    p_no_expire_in_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_out_n |-> !wd_expire);
endmodule

bind wdt_supervisor wdsup_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvd_below (lvd_below),
    .rst_out_n (rst_out_n),
    .tick      (tick),
    .wd_expire (wd_expire),
    .wd_en     (s_q.wd_en),
    .flag_wdt  (s_q.cause.wdt),
    .flag_lv   (s_q.cause.lv),
    .clr_wdt   (wr_cause && reg_wdata[7])
);

// File: tb/wdt_supervisor_tb.sv
module wdt_supervisor_tb;
    localparam int TD = 4;
    localparam int UT = 5;
    localparam int PT = 5;
    localparam int PW = PT * TD;

    localparam int NV = 6;
    // {addr, write data, expected readback}
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 8'hFF, 8'h9F},
        {2'd0, 8'h05, 8'h05},
        {2'd2, 8'hFE, 8'h02},
        {2'd2, 8'h03, 8'h03},
        {2'd3, 8'hAA, 8'h00},
        {2'd0, 8'h00, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lvd_below = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] lvd_sel;
    logic       rst_out_n;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wdt_supervisor #(.TICK_DIV(TD), .UNIT_TICKS(UT), .PULSE_TICKS(PT)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvd_below (lvd_below),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lvd_sel   (lvd_sel),
        .rst_out_n (rst_out_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic lv_pulse();
        lvd_below = 1'b1;
        @(negedge clk);
        lvd_below = 1'b0;
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!rst_out_n && n < 5000) begin n++; @(negedge clk); end
    endtask

    task automatic count_high(input int cap, output int n);
        n = 0;
        while (rst_out_n && n < cap) begin n++; @(negedge clk); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run hung actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int v;
        int n;
        repeat (3) @(negedge clk);
        chk("R1 reset low while rst_n", int'(rst_out_n), 0);
        rst_n = 1'b1;
        count_low(n);
        chk("R1 power-up width", n, PW);
        rd(2'd1, v);
        chk("R1 power-up flags", v, 8'h40);

        // register readback vectors
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][17:16], VEC[i][15:8]);
            rd(VEC[i][17:16], v);
            chk("R8 readback", v, int'(VEC[i][7:0]));
        end
        chk("R8 lvd_sel output", int'(lvd_sel), 3);

        // low-voltage pulse, flags, W1C
        lv_pulse();
        count_low(n);
        chk("R2 single event width", n, PW);
        rd(2'd1, v);
        chk("R7 lv flag added", v, 8'h60);
        wr(2'd1, 8'h40);
        rd(2'd1, v);
        chk("R7 clear por only", v, 8'h20);
        wr(2'd1, 8'hE0);
        rd(2'd1, v);
        chk("R7 clear all", v, 8'h00);

        // set wins over clear
        lvd_below = 1'b1;
        wr(2'd1, 8'h20);
        lvd_below = 1'b0;
        count_low(n);
        chk("R5 release after last below", n, PW);
        rd(2'd1, v);
        chk("R7 set beats clear", v, 8'h20);

        // long low-voltage hold
        lvd_below = 1'b1;
        n = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (!rst_out_n) n++;
        end
        chk("R5 held low while below", n, 50);
        lvd_below = 1'b0;
        count_low(n);
        chk("R5 release width", n, PW);

        // retrigger during pulse
        lv_pulse();
        repeat (9) @(negedge clk);
        lv_pulse();
        count_low(n);
        chk("R6 retrigger restarts width", n, PW);
        wr(2'd1, 8'hE0);

        // watchdog timeout 2 units
        wr(2'd0, 8'h82);
        wr(2'd1, 8'h0A);
        count_high(1000, n);
        chk("R3 timeout", n, 2 * UT * TD);
        count_low(n);
        chk("R2 watchdog pulse width", n, PW);
        rd(2'd1, v);
        chk("R7 wdt flag", v, 8'h80);
        count_high(1000, n);
        chk("R9 full timeout after release", n, 2 * UT * TD);
        count_low(n);

        // wrong key ignored
        wr(2'd1, 8'h0A);
        repeat (19) @(negedge clk);
        wr(2'd1, 8'h05);
        count_high(1000, n);
        chk("R4 wrong key ignored", n, 2 * UT * TD - 20);
        count_low(n);

        // right key restarts
        wr(2'd1, 8'h0A);
        repeat (19) @(negedge clk);
        wr(2'd1, 8'h0A);
        count_high(1000, n);
        chk("R4 key restarts", n, 2 * UT * TD);
        count_low(n);

        // reset just before timeout holds the count
        wr(2'd1, 8'h0A);
        repeat (29) @(negedge clk);
        lv_pulse();
        count_low(n);
        chk("R9 pulse before timeout", n, PW);
        count_high(1000, n);
        chk("R9 count held during reset", n, 2 * UT * TD);
        count_low(n);

        // disabled cases
        wr(2'd0, 8'h80);
        wr(2'd1, 8'h0A);
        count_high(300, n);
        chk("R3 zero timeout never expires", n, 300);
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h0A);
        count_high(300, n);
        chk("R3 disabled never expires", n, 300);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule